// File: doc/BRIEF.md
# Network controller command/status and interrupt unit

This block is the host-visible control window of a network controller. The host reads a 16-bit status word whose upper bits are sticky event flags and whose lower byte mirrors the current states of the receive engine and the command engine. The host clears flags by writing a mask of them to a separate acknowledge byte. It posts engine commands through a command byte, and it controls the interrupt line through a mask bit and a software-interrupt bit. A 32-bit pointer register supplies the address argument of commands that need one.

The DMA engines sit outside the block. They report events through one-cycle strobes and report their states on level inputs. They take commands from a one-cycle command pulse that carries the code and, where the code uses one, the pointer value. The command byte reads back the posted code until the engine signals acceptance and then reads zero, so the host polls it for zero before posting again. One level interrupt output is asserted while any event flag is set and the mask bit is clear.

The host port is dword-addressed with byte strobes. Word 0 holds the status word (bytes 0 and 1; byte 1 is also the acknowledge byte when written), the command byte (byte 2) and the interrupt control byte (byte 3). Word 1 holds the pointer. Reads have one cycle of latency.

Top module: `nic_csr_irq`

## Requirements
- R1: After reset all event flags are zero, the mask bit (word 0 bit 24) is one, both unit states read idle (zero), the command byte reads zero, `irq_o` is low and `host_rdata` is zero. A word 0 read then returns 0x0100_0000.
- R2: A pulse on `ev_strobe_i[j]` sets status bit 10+j on the next clock edge. The mapping is j=5 command executed (0x8000), j=4 frame received (0x4000), j=3 command unit left active (0x2000), j=2 receive not ready (0x1000), j=1 management done (0x0800) and j=0 software interrupt (0x0400). The flag stays set until it is acknowledged, and it reads in word 0 bits 15..10.
- R3: A write to byte 1 of word 0 clears every flag whose bit is set in the written byte: byte bit n clears status bit n+8. Flags whose bits are clear in that byte keep their value. A write to byte 0 has no effect.
- R4: When a strobe and an acknowledge of the same flag fall in the same cycle, the flag ends up set.
- R5: `irq_o` is a registered output that is high exactly when at least one flag is set and the mask bit is zero. It changes on the same edge as the flag or mask update that causes the change, so it falls on the edge that clears the last flag.
- R6: Writing byte 3 of word 0 loads the mask bit from data bit 24. Writing one to data bit 25 sets the software-interrupt flag (status bit 10). Bits 31..25 read as zero.
- R7: A nonzero code written to byte 2 (data bits 23..16) while no command is pending becomes pending and reads back in word 0 bits 23..16. `cmd_valid_o` is high for exactly the one cycle after the write, with `cmd_code_o` equal to the code. A `cmd_accept_i` pulse while a command is pending makes the command byte read zero.
- R8: With the pulse, `cmd_ptr_o` carries the pointer register value when the upper nibble of the code is 0x1, 0x4 or 0x6, or when the lower nibble is 0x1, 0x5 or 0x6. For any other code it carries zero.
- R9: A command write while a command is pending changes nothing: there is no pulse and the pending code is kept. A write of code 0x00 posts nothing and produces no pulse.
- R10: The command engine state `cu_state_i` (idle 0, suspended 1, active 2) reads in status bits 7..6. The receive engine state `ru_state_i` (idle 0x00, suspended 0x04, no resources 0x08, ready 0x10) reads in bits 5..0. Each input is registered once before it is read back.
- R11: Word 1 is the pointer register. Each byte strobe writes its own byte and leaves the other bytes unchanged, and word 1 reads return the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write enable |
| host_waddr | input | 1 | Host write dword address (0 control, 1 pointer) |
| host_wstrb | input | 4 | Host write byte strobes |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read enable |
| host_raddr | input | 1 | Host read dword address |
| host_rdata | output | 32 | Registered read data, valid one cycle after the read |
| ev_strobe_i | input | 6 | Event strobes from the engines, one per flag |
| ru_state_i | input | 6 | Receive engine state |
| cu_state_i | input | 2 | Command engine state |
| cmd_accept_i | input | 1 | Engine accepts the pending command |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_code_o | output | 8 | Command code with the pulse |
| cmd_ptr_o | output | 32 | Pointer argument with the pulse, zero if the code takes none |
| irq_o | output | 1 | Level interrupt request |

## Verification
The directed cases set flags one at a time and acknowledge each one. These cases tell the bit mapping of the acknowledge byte apart from a plain overwrite, and they catch a set-versus-clear priority that favours the clear in the same cycle. Commands are posted with pointer-using and pointer-free codes, and again while another command is still pending, so that a missing busy interlock or a wrong pointer decode shows up on the command pulse. The random phase mixes sparse strobes, partial-strobe writes to both words, random accepts and reads every cycle. A reference model checks the interrupt line, the command pulse and every read, which exposes ordering faults between masking, acknowledging and posting.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int FLAG_N   = 6;
  localparam int RU_W     = 6;
  localparam int CU_W     = 2;
  localparam int CODE_W   = 8;
  localparam int LANE_N   = 4;
  localparam int LANE_W   = 8;
  localparam int DATA_W   = LANE_N * LANE_W;
  // byte lanes of control word 0
  localparam int LANE_ACK  = 1;
  localparam int LANE_CMD  = 2;
  localparam int LANE_ICTL = 3;
  // bit inside the acknowledge byte that maps to flag 0
  localparam int ACK_FLAG_LSB = 2;
  localparam int ICTL_MASK = 0;
  localparam int ICTL_SWI  = 1;
  localparam int FLAG_SWI  = 0;

  function automatic logic code_takes_ptr(input logic [CODE_W-1:0] c);
    logic hi, lo;
    hi = (c[7:4] == 4'h1) || (c[7:4] == 4'h4) || (c[7:4] == 4'h6);
    lo = (c[3:0] == 4'h1) || (c[3:0] == 4'h5) || (c[3:0] == 4'h6);
    return hi || lo;
  endfunction
endpackage

// File: rtl/csr_evt_flags.sv
module csr_evt_flags #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_q,
  output logic [N-1:0] flags_nxt
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    // set has priority so a simultaneous event is never lost
    assign flags_nxt[i] = set_i[i] | (flags_q[i] & ~clr_i[i]);

    always_ff @(posedge clk) begin
      if (rst) flags_q[i] <= 1'b0;
      else     flags_q[i] <= flags_nxt[i];
    end

    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flags_q[i]);

    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !flags_q[i]);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (flags_q[i] && !clr_i[i]) |=> flags_q[i]);
  end
endmodule

// File: rtl/csr_cmd_post.sv
module csr_cmd_post
  import nic_csr_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int PW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          post_i,
  input  logic [CW-1:0] code_i,
  input  logic [PW-1:0] ptr_i,
  input  logic          accept_i,
  output logic [CW-1:0] pend_code_o,
  output logic          cmd_valid_o,
  output logic [CW-1:0] cmd_code_o,
  output logic [PW-1:0] cmd_ptr_o
);
  logic busy;
  logic take;

  assign busy = (pend_code_o != '0);
  assign take = post_i && !busy && (code_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_code_o <= '0;
      cmd_valid_o <= 1'b0;
      cmd_code_o  <= '0;
      cmd_ptr_o   <= '0;
    end else begin
      cmd_valid_o <= take;
      if (take) begin
        pend_code_o <= code_i;
        cmd_code_o  <= code_i;
        cmd_ptr_o   <= code_takes_ptr(code_i) ? ptr_i : '0;
      end else if (busy && accept_i) begin
        pend_code_o <= '0;
      end
    end
  end

  p_pulse_once_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o);

  p_pending_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !accept_i) |=> $stable(pend_code_o));

  p_pulse_matches_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> (pend_code_o == cmd_code_o));
endmodule

// File: rtl/csr_irq_out.sv
module csr_irq_out #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags_nxt_i,
  input  logic         mask_nxt_i,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (|flags_nxt_i) && !mask_nxt_i;
  end
endmodule

// File: rtl/nic_csr_irq.sv
module nic_csr_irq
  import nic_csr_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_waddr,
  input  logic [LANE_N-1:0] host_wstrb,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [FLAG_N-1:0] ev_strobe_i,
  input  logic [RU_W-1:0]   ru_state_i,
  input  logic [CU_W-1:0]   cu_state_i,
  input  logic              cmd_accept_i,
  output logic              cmd_valid_o,
  output logic [CODE_W-1:0] cmd_code_o,
  output logic [DATA_W-1:0] cmd_ptr_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PTR  = ADDR_W'(1);
  localparam int PAD_W = LANE_W - (RU_W + CU_W);

  logic              wr_ctrl, wr_ptr;
  logic              ack_wr, cmd_wr, ictl_wr;
  logic [LANE_W-1:0] ack_byte, cmd_byte, ictl_byte;
  logic [FLAG_N-1:0] set_v, clr_v, flags_q, flags_nxt;
  logic              mask_q, mask_nxt;
  logic [DATA_W-1:0] ptr_q;
  logic [RU_W-1:0]   ru_q;
  logic [CU_W-1:0]   cu_q;
  logic [CODE_W-1:0] pend_code;
  logic [DATA_W-1:0] word_ctrl;

  // write decode
  assign wr_ctrl   = host_wr && (host_waddr == A_CTRL);
  assign wr_ptr    = host_wr && (host_waddr == A_PTR);
  assign ack_wr    = wr_ctrl && host_wstrb[LANE_ACK];
  assign cmd_wr    = wr_ctrl && host_wstrb[LANE_CMD];
  assign ictl_wr   = wr_ctrl && host_wstrb[LANE_ICTL];
  assign ack_byte  = host_wdata[LANE_ACK*LANE_W +: LANE_W];
  assign cmd_byte  = host_wdata[LANE_CMD*LANE_W +: LANE_W];
  assign ictl_byte = host_wdata[LANE_ICTL*LANE_W +: LANE_W];

  always_comb begin
    clr_v = '0;
    if (ack_wr) clr_v = ack_byte[ACK_FLAG_LSB +: FLAG_N];
    set_v = ev_strobe_i;
    if (ictl_wr && ictl_byte[ICTL_SWI]) set_v[FLAG_SWI] = 1'b1;
  end

  csr_evt_flags #(.N(FLAG_N)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .set_i     (set_v),
    .clr_i     (clr_v),
    .flags_q   (flags_q),
    .flags_nxt (flags_nxt)
  );

  // interrupt mask
  assign mask_nxt = ictl_wr ? ictl_byte[ICTL_MASK] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= 1'b1;
    else     mask_q <= mask_nxt;
  end

  csr_irq_out #(.N(FLAG_N)) u_irq (
    .clk         (clk),
    .rst         (rst),
    .flags_nxt_i (flags_nxt),
    .mask_nxt_i  (mask_nxt),
    .irq_o       (irq_o)
  );

  // general pointer, byte-writable
  for (genvar b = 0; b < LANE_N; b++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)                       ptr_q[b*LANE_W +: LANE_W] <= '0;
      else if (wr_ptr && host_wstrb[b]) ptr_q[b*LANE_W +: LANE_W] <= host_wdata[b*LANE_W +: LANE_W];
    end
  end

  csr_cmd_post #(.CW(CODE_W), .PW(DATA_W)) u_cmd (
    .clk         (clk),
    .rst         (rst),
    .post_i      (cmd_wr),
    .code_i      (cmd_byte[CODE_W-1:0]),
    .ptr_i       (ptr_q),
    .accept_i    (cmd_accept_i),
    .pend_code_o (pend_code),
    .cmd_valid_o (cmd_valid_o),
    .cmd_code_o  (cmd_code_o),
    .cmd_ptr_o   (cmd_ptr_o)
  );

  // unit state mirrors
  always_ff @(posedge clk) begin
    if (rst) begin
      ru_q <= '0;
      cu_q <= '0;
    end else begin
      ru_q <= ru_state_i;
      cu_q <= cu_state_i;
    end
  end

  // read path
  always_comb begin
    word_ctrl = '0;
    word_ctrl[RU_W-1:0]                          = ru_q;
    word_ctrl[RU_W +: CU_W]                      = cu_q;
    word_ctrl[LANE_ACK*LANE_W+ACK_FLAG_LSB +: FLAG_N] = flags_q;
    word_ctrl[LANE_CMD*LANE_W +: CODE_W]         = pend_code;
    word_ctrl[LANE_ICTL*LANE_W+ICTL_MASK]        = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= (host_raddr == A_PTR) ? ptr_q : word_ctrl;
  end

  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    mask_q |-> !irq_o);

  p_irq_follows_r5: assert property (@(posedge clk) disable iff (rst)
    ((flags_q != '0) && !mask_q) |-> irq_o);

  p_irq_cause_r5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flags_q != '0));

  initial begin
    a_pad_r10: assert (PAD_W >= 0);
  end
endmodule

// File: tb/nic_csr_irq_tb.sv
module nic_csr_irq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        b_wr = 0, b_waddr = 0, b_rd = 0, b_raddr = 0, b_accept = 0;
  logic [3:0]  b_wstrb = 0;
  logic [31:0] b_wdata = 0;
  logic [5:0]  b_ev = 0, b_ru = 0;
  logic [1:0]  b_cu = 0;
  logic [31:0] host_rdata, cmd_ptr_o;
  logic [7:0]  cmd_code_o;
  logic        cmd_valid_o, irq_o;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [5:0]  m_flags, m_ru;
  logic [1:0]  m_cu;
  logic        m_mask, m_irq, m_vld;
  logic [7:0]  m_code, m_vcode;
  logic [31:0] m_ptr, m_vptr, m_rdata;

  always #2 clk = ~clk;

  nic_csr_irq u_dut (
    .clk(clk), .rst(rst), .host_wr(b_wr), .host_waddr(b_waddr),
    .host_wstrb(b_wstrb), .host_wdata(b_wdata), .host_rd(b_rd),
    .host_raddr(b_raddr), .host_rdata(host_rdata), .ev_strobe_i(b_ev),
    .ru_state_i(b_ru), .cu_state_i(b_cu), .cmd_accept_i(b_accept),
    .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o),
    .cmd_ptr_o(cmd_ptr_o), .irq_o(irq_o)
  );

  function automatic logic takes_ptr(input logic [7:0] c);
    case (c[7:4]) 4'h1, 4'h4, 4'h6: return 1'b1; default: ; endcase
    case (c[3:0]) 4'h1, 4'h5, 4'h6: return 1'b1; default: ; endcase
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_flags = 0; m_ru = 0; m_cu = 0; m_mask = 1; m_irq = 0; m_vld = 0;
    m_code = 0; m_vcode = 0; m_ptr = 0; m_vptr = 0; m_rdata = 0;
  endtask

  task automatic clear_in();
    b_wr = 0; b_rd = 0; b_accept = 0; b_ev = 0; b_wstrb = 0; b_wdata = 0;
  endtask

  task automatic step();
    logic [5:0] clr_v, set_v, f_n;
    logic w0, m_n, post;
    logic [31:0] rd_n;
    @(posedge clk);
    rd_n = m_rdata;
    if (b_rd) rd_n = b_raddr ? m_ptr : {7'b0, m_mask, m_code, m_flags, 2'b00, m_cu, m_ru};
    w0 = b_wr && !b_waddr;
    clr_v = (w0 && b_wstrb[1]) ? b_wdata[15:10] : 6'd0;
    set_v = b_ev | {5'd0, w0 && b_wstrb[3] && b_wdata[25]};
    f_n = (m_flags & ~clr_v) | set_v;
    m_n = (w0 && b_wstrb[3]) ? b_wdata[24] : m_mask;
    post = w0 && b_wstrb[2] && (m_code == 0) && (b_wdata[23:16] != 0);
    m_vld = post;
    if (post) begin
      m_vcode = b_wdata[23:16];
      m_vptr  = takes_ptr(b_wdata[23:16]) ? m_ptr : 32'd0;
      m_code  = b_wdata[23:16];
    end else if (m_code != 0 && b_accept) m_code = 0;
    if (b_wr && b_waddr)
      for (int b = 0; b < 4; b++) if (b_wstrb[b]) m_ptr[b*8 +: 8] = b_wdata[b*8 +: 8];
    m_ru = b_ru; m_cu = b_cu; m_flags = f_n; m_mask = m_n;
    m_irq = (f_n != 0) && !m_n; m_rdata = rd_n;
    @(negedge clk);
    check("R5 irq", {31'd0, irq_o}, {31'd0, m_irq});
    check("R7 pulse", {31'd0, cmd_valid_o}, {31'd0, m_vld});
    if (m_vld) begin
      check("R7 code", {24'd0, cmd_code_o}, {24'd0, m_vcode});
      check("R8 ptr", cmd_ptr_o, m_vptr);
    end
    check("R2 read", host_rdata, m_rdata);
    clear_in();
  endtask

  task automatic wr(input logic a, input logic [3:0] s, input logic [31:0] d);
    b_wr = 1; b_waddr = a; b_wstrb = s; b_wdata = d;
  endtask

  task automatic rd(input logic a);
    b_rd = 1; b_raddr = a;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, 32'd0);
    check("R1 rdata", host_rdata, 32'd0);
    rd(0); step();
    check("R1 word0", host_rdata, 32'h0100_0000);
    // R2 event sets flag
    b_ev = 6'b100000; step();
    rd(0); step();
    check("R2 flag", host_rdata, 32'h0100_8000);
    // R5 unmask raises irq
    wr(0, 4'b1000, 32'h0); step();
    check("R5 unmask", {31'd0, irq_o}, 32'd1);
    // R3 acknowledge clears
    wr(0, 4'b0010, 32'h0000_8000); step();
    check("R3 irq low", {31'd0, irq_o}, 32'd0);
    wr(0, 4'b0001, 32'h0000_00ff); rd(0); step();
    check("R3 cleared", host_rdata, 32'h0000_0000);
    // R4 same-cycle strobe and ack
    b_ev = 6'b010000; step();
    b_ev = 6'b010000; wr(0, 4'b0010, 32'h0000_4000); step();
    rd(0); step();
    check("R4 kept", host_rdata, 32'h0000_4000);
    wr(0, 4'b0010, 32'h0000_4000); step();
    check("R4 cleared irq", {31'd0, irq_o}, 32'd0);
    // R6 mask and software interrupt
    wr(0, 4'b1000, 32'h0300_0000); step();
    check("R6 masked", {31'd0, irq_o}, 32'd0);
    rd(0); step();
    check("R6 swi", host_rdata, 32'h0100_0400);
    wr(0, 4'b1010, 32'h0000_0400); step();
    // R11 pointer byte writes
    wr(1, 4'b1111, 32'h1234_5678); step();
    wr(1, 4'b0100, 32'hffab_ffff); step();
    rd(1); step();
    check("R11 ptr", host_rdata, 32'h12ab_5678);
    // R7 R8 command post
    wr(0, 4'b0100, 32'h0010_0000); step();
    check("R8 start ptr", cmd_ptr_o, 32'h12ab_5678);
    check("R7 start pulse", {31'd0, cmd_valid_o}, 32'd1);
    rd(0); step();
    check("R7 pending", {24'd0, host_rdata[23:16]}, 32'h10);
    // R9 post while pending ignored
    wr(0, 4'b0100, 32'h0020_0000); step();
    check("R9 no pulse", {31'd0, cmd_valid_o}, 32'd0);
    rd(0); step();
    check("R9 kept", {24'd0, host_rdata[23:16]}, 32'h10);
    b_accept = 1; step();
    rd(0); step();
    check("R7 accepted", {24'd0, host_rdata[23:16]}, 32'h00);
    wr(0, 4'b0100, 32'h0020_0000); step();
    check("R8 no ptr", cmd_ptr_o, 32'h0);
    b_accept = 1; step();
    wr(0, 4'b0100, 32'h0000_0000); step();
    check("R9 zero code", {31'd0, cmd_valid_o}, 32'd0);
    // R10 unit states
    b_ru = 6'h10; b_cu = 2'd2; step();
    rd(0); step();
    check("R10 states", {24'd0, host_rdata[7:0]}, 32'h90);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] codes [14];
      codes = '{8'h00, 8'h10, 8'h20, 8'h40, 8'h50, 8'h60, 8'h70,
                8'h01, 8'h02, 8'h04, 8'h05, 8'h06, 8'h07, 8'h11};
      if ($urandom_range(9) < 3) begin
        b_wr = 1; b_waddr = $urandom_range(1); b_wstrb = 4'($urandom);
        b_wdata = $urandom;
        if (!b_waddr) begin
          b_wdata[23:16] = codes[$urandom_range(13)];
          b_wdata[31:26] = 0;
        end
      end
      for (int j = 0; j < 6; j++) b_ev[j] = ($urandom_range(15) == 0);
      b_accept = ($urandom_range(4) == 0);
      b_rd = $urandom_range(1); b_raddr = $urandom_range(1);
      b_ru = 6'($urandom); b_cu = 2'($urandom);
      step();
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule